// File: doc/BRIEF.md
# Packet-Splitting DMA Request Sequencer

This block paces an external fly-by DMA controller that moves bytes between system memory and the FIFO of one endpoint. Software picks the endpoint, the direction and the trigger, then sets the request enable. The block raises a request line. It accepts a byte on each cycle in which the controller's acknowledge and the strobe for that direction are high. It turns every accepted byte into a single-cycle read or write strobe on the selected endpoint's FIFO port. Accesses from the processor always win: while the processor's chip select is high, the acknowledge is ignored.

In standard mode a request runs either while the endpoint's FIFO warning flag is high, or as a burst that starts when the packet engine reports a finished packet. In automatic mode a long transfer is cut into fixed-size packets. After each packet the block queues the next transmit, or re-enables reception, by itself. It stops when its packet count is used up or when a short receive packet arrives, and it then pulses a completion event. The USB packet engine is outside the block. It is seen only through the per-endpoint packet-done pulses, received lengths and warning flags.

The DMA handshake is a plain request/acknowledge pair, not a valid/ready stream. Back-pressure works like this: the external controller stalls simply by keeping the acknowledge low, and the block holds its request until the expected bytes have arrived.

Top module: `dma_pkt_seq`

## Requirements
- R1: After reset, drq, every FIFO strobe, every arming pulse, done_evt and cfg_err are low.
- R2: A byte is accepted only while drq is high, dack is high, cpu_cs is low and the direction's strobe is high (wr_stb for transmit, dir_rx=0; rd_stb for receive, dir_rx=1). Each accepted byte gives a one-cycle pulse on bit i of fifo_wr (transmit) or fifo_rd (receive), where i is the endpoint number latched from ep_sel.
- R3: While cpu_cs is high, dack is ignored: no FIFO strobe is produced and no byte is counted.
- R4: In standard mode with warn_en=0, a pkt_done pulse from the selected endpoint raises drq on the next cycle. The burst that follows is PKT_BYTES bytes for transmit and the reported pkt_len for receive. Flags from other endpoints have no effect, and no arming pulse or done_evt is produced.
- R5: In standard mode with warn_en=1, drq rises one cycle after the selected endpoint's fifo_warn goes high. It falls one cycle after fifo_warn is low with dack low.
- R6: drq is low in the cycle after the clock edge that accepts the last byte of a burst.
- R7: In automatic transmit, drq rises right after start. After every PKT_BYTES bytes, tx_arm pulses for the selected endpoint one cycle after the last byte. The next burst waits for that endpoint's pkt_done. In total pkt_count+1 packets are moved.
- R8: In automatic receive, rx_arm pulses for the selected endpoint one cycle after start, and again after every full packet that is not the last one. Each pkt_done starts a burst of pkt_len bytes.
- R9: Automatic mode ends after pkt_count+1 packets, or after a receive packet with pkt_len below PKT_BYTES (zero included). done_evt then pulses once, and drq stays low until dma_en is cleared.
- R10: If dma_en is cleared while drq and dack are high, drq stays high until dack goes low, and falls on the cycle after.
- R11: Mode, direction, trigger and endpoint are taken when dma_en turns on. If auto_en rises while dma_en is already on, the rise is ignored and cfg_err is set, and cfg_err stays set until dma_en is cleared.
- R12: At most one bit across fifo_wr and fifo_rd is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | Request enable; turning it on starts a transfer |
| auto_en | input | 1 | Automatic packet mode, set before or with dma_en |
| warn_en | input | 1 | Standard mode trigger: 1 warning level, 0 packet done |
| dir_rx | input | 1 | 0 transmit (memory to FIFO), 1 receive (FIFO to memory) |
| ep_sel | input | EP_W ($clog2(N_EP)) | Endpoint number, below N_EP |
| pkt_count | input | CNT_W | Automatic mode packets minus one |
| fifo_warn | input | N_EP | Per-endpoint FIFO warning level |
| pkt_done | input | N_EP | Per-endpoint packet finished pulse |
| pkt_len | input | N_EP*LEN_W | Per-endpoint received length, LEN_W=$clog2(PKT_BYTES+1), endpoint i in bits [i*LEN_W +: LEN_W] |
| cpu_cs | input | 1 | Processor access in progress (active high) |
| dack | input | 1 | DMA acknowledge (active high) |
| rd_stb | input | 1 | Bus read strobe |
| wr_stb | input | 1 | Bus write strobe |
| drq | output | 1 | DMA request |
| fifo_wr | output | N_EP | Per-endpoint FIFO write strobe |
| fifo_rd | output | N_EP | Per-endpoint FIFO read strobe |
| tx_arm | output | N_EP | Queue transmit, last byte marked |
| rx_arm | output | N_EP | Re-enable reception |
| done_evt | output | 1 | Automatic transfer finished |
| cfg_err | output | 1 | Automatic mode requested too late |

## Verification
The bench builds the block with PKT_BYTES=8, CNT_W=3 and N_EP=3. With these values it can sweep every packet count the counter can hold, including the full count of eight packets, in both directions, and rotate through all three endpoints. For receive it places a short packet at every position within small counts, with lengths that include zero, so both stopping rules are hit at the first, middle and last packet. Standard-mode triggers, processor priority inside a burst, a disable during a held acknowledge and the late automatic-mode error are each driven on their own.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BURST,
    ST_LEVEL,
    ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic auto_m;
    logic rx_m;
    logic warn_m;
  } seq_mode_t;
endpackage

// File: rtl/dma_seq_bytes.sv
module dma_seq_bytes #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             step,
  output logic             last
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgt_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      tgt_q <= load_len;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = step && (cnt_q == tgt_q - 1'b1);
endmodule

// File: rtl/dma_seq_pkts.sv
module dma_seq_pkts #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dma_seq_epsel.sv
module dma_seq_epsel #(
  parameter int N_EP  = 3,
  parameter int EP_W  = 2,
  parameter int LEN_W = 7
) (
  input  logic [EP_W-1:0]       ep,
  input  logic [N_EP-1:0]       fifo_warn,
  input  logic [N_EP-1:0]       pkt_done,
  input  logic [N_EP*LEN_W-1:0] pkt_len,
  output logic                  warn_sel,
  output logic                  done_sel,
  output logic [LEN_W-1:0]      len_sel,
  input  logic                  wr_one,
  input  logic                  rd_one,
  input  logic                  tx_one,
  input  logic                  rx_one,
  output logic [N_EP-1:0]       fifo_wr,
  output logic [N_EP-1:0]       fifo_rd,
  output logic [N_EP-1:0]       tx_arm,
  output logic [N_EP-1:0]       rx_arm
);
  always_comb begin
    warn_sel = 1'b0;
    done_sel = 1'b0;
    len_sel  = '0;
    for (int i = 0; i < N_EP; i++) begin
      if (ep == EP_W'(i)) begin
        warn_sel = fifo_warn[i];
        done_sel = pkt_done[i];
        len_sel  = pkt_len[i*LEN_W +: LEN_W];
      end
    end
  end

  for (genvar g = 0; g < N_EP; g++) begin : g_ep
    logic hit;
    assign hit        = (ep == EP_W'(g));
    assign fifo_wr[g] = hit && wr_one;
    assign fifo_rd[g] = hit && rd_one;
    assign tx_arm[g]  = hit && tx_one;
    assign rx_arm[g]  = hit && rx_one;
  end
endmodule

// File: rtl/dma_pkt_seq.sv
module dma_pkt_seq
  import dma_seq_pkg::*;
#(
  parameter int PKT_BYTES = 64,
  parameter int CNT_W     = 8,
  parameter int N_EP      = 3,
  localparam int LEN_W    = $clog2(PKT_BYTES + 1),
  localparam int EP_W     = $clog2(N_EP)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dma_en,
  input  logic                  auto_en,
  input  logic                  warn_en,
  input  logic                  dir_rx,
  input  logic [EP_W-1:0]       ep_sel,
  input  logic [CNT_W-1:0]      pkt_count,
  input  logic [N_EP-1:0]       fifo_warn,
  input  logic [N_EP-1:0]       pkt_done,
  input  logic [N_EP*LEN_W-1:0] pkt_len,
  input  logic                  cpu_cs,
  input  logic                  dack,
  input  logic                  rd_stb,
  input  logic                  wr_stb,
  output logic                  drq,
  output logic [N_EP-1:0]       fifo_wr,
  output logic [N_EP-1:0]       fifo_rd,
  output logic [N_EP-1:0]       tx_arm,
  output logic [N_EP-1:0]       rx_arm,
  output logic                  done_evt,
  output logic                  cfg_err
);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(PKT_BYTES);

  seq_state_t       st_q;
  seq_mode_t        mode_q;
  logic [EP_W-1:0]  ep_q;
  logic             en_q, auto_en_q, err_q, short_q;
  logic             tx_arm_q, rx_arm_q, done_q;
  logic             warn_sel, done_sel;
  logic [LEN_W-1:0] len_sel, burst_len;
  logic             active, xfer, last, pkt_zero;
  logic             start, go_burst, zero_end, finish, pkt_dec;

  dma_seq_epsel #(.N_EP(N_EP), .EP_W(EP_W), .LEN_W(LEN_W)) u_epsel (
    .ep(ep_q), .fifo_warn(fifo_warn), .pkt_done(pkt_done), .pkt_len(pkt_len),
    .warn_sel(warn_sel), .done_sel(done_sel), .len_sel(len_sel),
    .wr_one(xfer && !mode_q.rx_m), .rd_one(xfer && mode_q.rx_m),
    .tx_one(tx_arm_q), .rx_one(rx_arm_q),
    .fifo_wr(fifo_wr), .fifo_rd(fifo_rd), .tx_arm(tx_arm), .rx_arm(rx_arm)
  );

  // Request is a pure function of registered state: no glitches on drq.
  assign active = (st_q == ST_BURST) || (st_q == ST_LEVEL);
  assign xfer   = active && dack && !cpu_cs && (mode_q.rx_m ? rd_stb : wr_stb);

  always_comb begin
    start     = dma_en && (st_q == ST_IDLE);
    burst_len = FULL_LEN;
    go_burst  = 1'b0;
    zero_end  = 1'b0;
    if (start) begin
      go_burst = auto_en && !dir_rx;
    end else if (dma_en && st_q == ST_WAIT && done_sel &&
                 (mode_q.auto_m || !mode_q.warn_m)) begin
      burst_len = mode_q.rx_m ? len_sel : FULL_LEN;
      go_burst  = (burst_len != '0);
      zero_end  = mode_q.auto_m && (burst_len == '0);
    end
    finish  = mode_q.auto_m && (pkt_zero || (mode_q.rx_m && short_q));
    pkt_dec = dma_en && (st_q == ST_BURST) && last && mode_q.auto_m && !finish;
  end

  dma_seq_bytes #(.LEN_W(LEN_W)) u_bytes (
    .clk(clk), .rst_n(rst_n), .load(go_burst), .load_len(burst_len),
    .step(xfer), .last(last)
  );

  dma_seq_pkts #(.CNT_W(CNT_W)) u_pkts (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(pkt_count),
    .dec(pkt_dec), .zero(pkt_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      mode_q    <= '0;
      ep_q      <= '0;
      en_q      <= 1'b0;
      auto_en_q <= 1'b0;
      err_q     <= 1'b0;
      short_q   <= 1'b0;
      tx_arm_q  <= 1'b0;
      rx_arm_q  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      en_q      <= dma_en;
      auto_en_q <= auto_en;
      tx_arm_q  <= 1'b0;
      rx_arm_q  <= 1'b0;
      done_q    <= 1'b0;
      if (!dma_en)                            err_q <= 1'b0;
      else if (auto_en && !auto_en_q && en_q) err_q <= 1'b1;
      if (go_burst) short_q <= (burst_len < FULL_LEN);

      if (!dma_en) begin
        // a byte cycle under way keeps the request until dack drops
        if (!(active && dack)) st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            mode_q   <= '{auto_m: auto_en, rx_m: dir_rx, warn_m: warn_en};
            ep_q     <= ep_sel;
            rx_arm_q <= auto_en && dir_rx;
            st_q     <= go_burst ? ST_BURST : ST_WAIT;
          end
          ST_WAIT: begin
            if (zero_end) begin
              st_q   <= ST_DONE;
              done_q <= 1'b1;
            end else if (go_burst) begin
              st_q <= ST_BURST;
            end else if (!mode_q.auto_m && mode_q.warn_m && warn_sel) begin
              st_q <= ST_LEVEL;
            end
          end
          ST_BURST: begin
            if (last) begin
              if (!mode_q.auto_m) begin
                st_q <= ST_WAIT;
              end else begin
                tx_arm_q <= !mode_q.rx_m;
                if (finish) begin
                  st_q   <= ST_DONE;
                  done_q <= 1'b1;
                end else begin
                  st_q     <= ST_WAIT;
                  rx_arm_q <= mode_q.rx_m;
                end
              end
            end
          end
          ST_LEVEL: begin
            if (!warn_sel && !dack) st_q <= ST_WAIT;
          end
          ST_DONE: st_q <= ST_DONE;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign drq      = active;
  assign done_evt = done_q;
  assign cfg_err  = err_q;
endmodule

// File: rtl/dma_pkt_seq_chk.sv
module dma_pkt_seq_chk #(
  parameter int N_EP = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dma_en,
  input logic            cpu_cs,
  input logic            dack,
  input logic            drq,
  input logic [N_EP-1:0] fifo_wr,
  input logic [N_EP-1:0] fifo_rd,
  input logic            done_evt,
  input logic            cfg_err
);
  // R12
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_wr, fifo_rd}));

  // R3
  cpu_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_cs |-> (fifo_wr == '0 && fifo_rd == '0));

  // R2
  strobe_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|{fifo_wr, fifo_rd}) |-> (drq && dack));

  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && dack && !dma_en) |=> drq);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> !drq);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !done_evt);

  // R11
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !cfg_err);
endmodule

bind dma_pkt_seq dma_pkt_seq_chk #(.N_EP(N_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .cpu_cs(cpu_cs), .dack(dack),
  .drq(drq), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd), .done_evt(done_evt),
  .cfg_err(cfg_err)
);

// File: tb/dma_pkt_seq_tb.sv
module dma_pkt_seq_tb;
  localparam int PKT   = 8;
  localparam int CNT_W = 3;
  localparam int N_EP  = 3;
  localparam int LEN_W = $clog2(PKT + 1);
  localparam int EP_W  = $clog2(N_EP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_en = 0, auto_en = 0, warn_en = 0, dir_rx = 0;
  logic [EP_W-1:0] ep_sel = '0;
  logic [CNT_W-1:0] pkt_count = '0;
  logic [N_EP-1:0] fifo_warn = '0, pkt_done = '0;
  logic [N_EP*LEN_W-1:0] pkt_len = '0;
  logic cpu_cs = 0, dack = 0, rd_stb = 0, wr_stb = 0;
  logic drq, done_evt, cfg_err;
  logic [N_EP-1:0] fifo_wr, fifo_rd, tx_arm, rx_arm;

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0, tx_cnt = 0, rx_cnt = 0, done_cnt = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  dma_pkt_seq #(.PKT_BYTES(PKT), .CNT_W(CNT_W), .N_EP(N_EP)) u_dut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .auto_en(auto_en),
    .warn_en(warn_en), .dir_rx(dir_rx), .ep_sel(ep_sel), .pkt_count(pkt_count),
    .fifo_warn(fifo_warn), .pkt_done(pkt_done), .pkt_len(pkt_len),
    .cpu_cs(cpu_cs), .dack(dack), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .drq(drq), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd), .tx_arm(tx_arm),
    .rx_arm(rx_arm), .done_evt(done_evt), .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      wr_cnt   += $countones(fifo_wr);
      rd_cnt   += $countones(fifo_rd);
      tx_cnt   += $countones(tx_arm);
      rx_cnt   += $countones(rx_arm);
      done_cnt += int'(done_evt);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // One byte cycle; checks the FIFO strobes in the middle of the cycle.
  task automatic do_byte(input bit rx, input int mask, input bit cs);
    dack = 1; cpu_cs = cs;
    if (rx) rd_stb = 1; else wr_stb = 1;
    #1;
    chk("R2 R12 strobe on selected endpoint", int'(rx ? fifo_rd : fifo_wr), cs ? 0 : mask);
    chk("R12 other direction quiet", int'(rx ? fifo_wr : fifo_rd), 0);
    tick();
    dack = 0; cpu_cs = 0; rd_stb = 0; wr_stb = 0;
    #1;
  endtask

  task automatic stop_dma();
    dma_en = 0; auto_en = 0; warn_en = 0;
    tick();
    tick();
  endtask

  task automatic auto_tx(input int n, input int ep);
    int w0, t0, d0;
    int mask;
    mask = 1 << ep;
    w0 = wr_cnt; t0 = tx_cnt; d0 = done_cnt;
    auto_en = 1; dir_rx = 0; ep_sel = EP_W'(ep); pkt_count = CNT_W'(n); dma_en = 1;
    tick();
    chk("R7 auto tx request at start", int'(drq), 1);
    chk("R11 no error when set together", int'(cfg_err), 0);
    ep_sel = EP_W'((ep + 1) % N_EP);
    for (int p = 0; p <= n; p++) begin
      for (int b = 0; b < PKT; b++) do_byte(0, mask, 0);
      chk("R6 request drops after last byte", int'(drq), 0);
      chk("R7 tx_arm after packet", int'(tx_arm), mask);
      chk("R9 done at count end", int'(done_evt), int'(p == n));
      if (p < n) begin
        tick();
        tick();
        chk("R7 waits for packet done", int'(drq), 0);
        pkt_done[ep] = 1;
        tick();
        pkt_done = '0;
        chk("R7 next burst after packet done", int'(drq), 1);
      end
    end
    tick();
    tick();
    chk("R9 stays quiet after done", int'(drq), 0);
    chk("R7 byte total", wr_cnt - w0, (n + 1) * PKT);
    chk("R7 tx_arm total", tx_cnt - t0, n + 1);
    chk("R9 single done", done_cnt - d0, 1);
    stop_dma();
  endtask

  task automatic auto_rx(input int n, input int s, input int ep);
    int r0, a0, d0, exp_bytes, exp_arm;
    int mask;
    bit fin;
    mask = 1 << ep;
    r0 = rd_cnt; a0 = rx_cnt; d0 = done_cnt;
    exp_bytes = 0; exp_arm = 1;
    auto_en = 1; dir_rx = 1; ep_sel = EP_W'(ep); pkt_count = CNT_W'(n); dma_en = 1;
    tick();
    chk("R8 rx_arm at start", int'(rx_arm), mask);
    chk("R8 no request before data", int'(drq), 0);
    for (int p = 0; p <= n; p++) begin
      int len;
      len = (p == s) ? (s * 3) % PKT : PKT;
      fin = (len < PKT) || (p == n);
      pkt_len = '0;
      pkt_len[ep*LEN_W +: LEN_W] = LEN_W'(len);
      pkt_done[ep] = 1;
      tick();
      pkt_done = '0;
      if (len == 0) begin
        chk("R9 zero-length packet ends", int'(done_evt), 1);
        chk("R9 no request on zero length", int'(drq), 0);
      end else begin
        chk("R8 burst after packet done", int'(drq), 1);
        for (int b = 0; b < len; b++) do_byte(1, mask, 0);
        exp_bytes += len;
        chk("R6 request drops after last byte", int'(drq), 0);
        chk("R9 done on short or count end", int'(done_evt), int'(fin));
        chk("R8 rx_arm after full packet", int'(rx_arm), fin ? 0 : mask);
        if (!fin) exp_arm++;
      end
      if (fin) break;
    end
    tick();
    chk("R9 stays quiet after done", int'(drq), 0);
    chk("R8 read total", rd_cnt - r0, exp_bytes);
    chk("R8 rx_arm total", rx_cnt - a0, exp_arm);
    chk("R9 single done", done_cnt - d0, 1);
    stop_dma();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 drq", int'(drq), 0);
    chk("R1 strobes", int'({fifo_wr, fifo_rd}), 0);
    chk("R1 arming", int'({tx_arm, rx_arm}), 0);
    chk("R1 done and error", int'({done_evt, cfg_err}), 0);

    // automatic transmit over every packet count
    for (int n = 0; n < (1 << CNT_W); n++) auto_tx(n, n % N_EP);

    // automatic receive with a short packet at each position (or none)
    for (int n = 0; n < 4; n++)
      for (int s = 0; s <= n + 1; s++) auto_rx(n, s, (n + s) % N_EP);

    // R4 standard transmit on packet done, with R3 processor access inside
    begin
      int w0, t0, d0;
      w0 = wr_cnt; t0 = tx_cnt; d0 = done_cnt;
      dir_rx = 0; ep_sel = 1; dma_en = 1;
      tick(); tick();
      chk("R4 idle until packet done", int'(drq), 0);
      pkt_done[2] = 1; tick(); pkt_done = '0; tick();
      chk("R4 other endpoint ignored", int'(drq), 0);
      pkt_done[1] = 1; tick(); pkt_done = '0;
      chk("R4 request after packet done", int'(drq), 1);
      for (int b = 0; b < 3; b++) do_byte(0, 2, 0);
      do_byte(0, 2, 1);
      for (int b = 3; b < PKT - 1; b++) do_byte(0, 2, 0);
      chk("R3 cpu cycle not counted", int'(drq), 1);
      do_byte(0, 2, 0);
      chk("R6 request drops after last byte", int'(drq), 0);
      chk("R4 byte total", wr_cnt - w0, PKT);
      chk("R4 no arming in standard", tx_cnt - t0, 0);
      chk("R4 no done in standard", done_cnt - d0, 0);
      stop_dma();
    end

    // R4 standard receive uses the reported length
    begin
      int r0;
      r0 = rd_cnt;
      dir_rx = 1; ep_sel = 0; dma_en = 1;
      tick();
      pkt_len = '0; pkt_len[0 +: LEN_W] = LEN_W'(5);
      pkt_done[0] = 1; tick(); pkt_done = '0;
      for (int b = 0; b < 5; b++) do_byte(1, 1, 0);
      chk("R4 receive burst length", rd_cnt - r0, 5);
      chk("R6 request drops after last byte", int'(drq), 0);
      stop_dma();
    end

    // R5 warning-level trigger
    begin
      int w0;
      w0 = wr_cnt;
      dir_rx = 0; ep_sel = 2; warn_en = 1; dma_en = 1;
      tick();
      fifo_warn[0] = 1; tick(); tick();
      chk("R5 other endpoint warning ignored", int'(drq), 0);
      fifo_warn[2] = 1; tick(); tick();
      chk("R5 request follows warning", int'(drq), 1);
      for (int b = 0; b < 3; b++) do_byte(0, 4, 0);
      fifo_warn = '0; tick();
      chk("R5 request drops with warning", int'(drq), 0);
      chk("R5 byte total", wr_cnt - w0, 3);
      stop_dma();
    end

    // R10 disable during a held acknowledge
    auto_en = 1; dir_rx = 0; ep_sel = 0; pkt_count = 1; dma_en = 1;
    tick();
    do_byte(0, 1, 0);
    do_byte(0, 1, 0);
    dack = 1; dma_en = 0; tick();
    chk("R10 request held during cycle", int'(drq), 1);
    tick();
    chk("R10 request still held", int'(drq), 1);
    dack = 0; tick();
    chk("R10 request withdrawn", int'(drq), 0);
    stop_dma();

    // R11 automatic mode set too late
    dir_rx = 0; ep_sel = 0; dma_en = 1;
    tick();
    auto_en = 1; tick();
    chk("R11 late auto flags error", int'(cfg_err), 1);
    tick();
    chk("R11 late auto ignored", int'(drq), 0);
    dma_en = 0; tick();
    chk("R11 error clears with enable", int'(cfg_err), 0);
    stop_dma();

    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule